// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a subword-parallel integer execution unit. Each issued operation takes two operand words, an opcode and a lane-size code, treats the words as vectors of equal lanes, and returns one result word. The result and its valid flag are registered, so both appear one clock after the issue. Lane arithmetic never lets a carry, borrow or shifted bit leak into a neighbouring lane.

The operations fall into four groups:
- Lane arithmetic: add and subtract (wrapping or clamped), compare masks, 16-bit multiply and paired multiply-add.
- Lane shifts.
- Lane shuffles: narrowing pack and interleaving unpack.
- Full-width bitwise logic.

Operand, register, decode and memory handling belong to the surrounding datapath.

Lane-size code `lsz_i`: 0 = 8-bit lanes, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit.

Opcodes on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | subtract |
| 2 | compare-equal |
| 3 | compare-greater |
| 4 | multiply, low half |
| 5 | multiply, high half |
| 6 | multiply-add |
| 7 | shift left logical |
| 8 | shift right logical |
| 9 | shift right arithmetic |
| 10 | pack |
| 11 | unpack-low |
| 12 | unpack-high |
| 13 | AND |
| 14 | AND-with-inverted-b |
| 15 | OR |
| 16 | XOR |

Top module: `simd_alu`

## Requirements
- R1: With `sat_i`=0, add (0) and subtract (1) produce each lane result modulo 2^lane width, for lane codes 0, 1 and 2. No carry or borrow passes between lanes.
- R2: With `sat_i`=1 and `uns_i`=0, add and subtract treat lanes as signed two's complement. A result above the signed maximum is clamped to the maximum, and one below the signed minimum is clamped to the minimum.
- R3: With `sat_i`=1 and `uns_i`=1, add and subtract treat lanes as unsigned. An add that overflows gives all ones in the lane, and a subtract that underflows gives zero.
- R4: Compare-equal (2) and compare-greater (3) fill each lane with all ones when the condition holds and all zeros otherwise, for lane codes 0, 1 and 2. Compare-greater is a signed comparison of a against b.
- R5: Multiply-low (4) and multiply-high (5) form the signed 32-bit product of each pair of 16-bit lanes, whatever `lsz_i` is. Code 4 returns product bits 15:0 and code 5 returns bits 31:16, each in the same 16-bit lane.
- R6: Multiply-add (6) sums the signed products of 16-bit lanes 2k and 2k+1 into 32-bit lane k, wrapping modulo 2^32.
- R7: Logical shifts left (7) and right (8) work on lane codes 1, 2 and 3. Each lane is shifted by the unsigned count in `b_i[63:0]`, zeros fill the vacated bits, and a count of lane width or more gives zero.
- R8: Arithmetic right shift (9) works on lane codes 1 and 2 and replicates each lane's sign bit. A count of lane width or more gives a lane filled with its sign bit.
- R9: Pack (10) works on lane codes 1 and 2. Each lane of a, then each lane of b, is narrowed to half width in order from the low end of the result. Narrowing clamps to the signed half-width range when `uns_i`=0, and to the unsigned half-width range when `uns_i`=1 (negative sources give zero).
- R10: Unpack-low (11) builds result lanes a0, b0, a1, b1 and so on from the lower half of the lanes, for lane codes 0, 1 and 2. Unpack-high (12) does the same with the upper half of the lanes.
- R11: Opcodes 13 to 16 give a&b, a&~b, a|b and a^b over the full word.
- R12: Some issues give an all-zero result:
  - opcode 17 or above;
  - lane code 3 with add, subtract, compare or unpack;
  - lane code 0 with a shift or pack;
  - lane code 3 with arithmetic shift or pack.
- R13: Reset clears `res_o` and `valid_o`. `valid_o` equals `valid_i` of the previous cycle. `res_o` takes the result of an issue one cycle later and keeps its value through cycles with `valid_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| op_i | input | 5 | Opcode |
| lsz_i | input | 2 | Lane-size code |
| sat_i | input | 1 | Clamp instead of wrap for add and subtract |
| uns_i | input | 1 | Unsigned range for clamping and packing |
| a_i | input | DW | First operand |
| b_i | input | DW | Second operand, also the shift count |
| valid_o | output | 1 | Result valid |
| res_o | output | DW | Registered result |

## Verification
The hardest situations to reach from the ports are the range edges inside a lane:
- sums that cross the signed or unsigned limit by exactly one;
- shift counts near and beyond the lane width, because the count comes from a full 64-bit operand that random values almost never make small.

The stimulus keeps random shift counts between 0 and 79, and often forces lane sign bits or all-ones patterns into the operands so that clamping and pack narrowing are hit. Directed issues cover the exact limit cases: 0x7F+1, 0x80-1, 0xFFFF+1, 0x8000 squared, and counts of 16, 63 and 100.

// File: rtl/simd_alu_pkg.sv
`timescale 1ns/1ps
package simd_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_SUB   = 5'd1,
      OP_CMPEQ = 5'd2,
      OP_CMPGT = 5'd3,
      OP_MULLO = 5'd4,
      OP_MULHI = 5'd5,
      OP_MADD  = 5'd6,
      OP_SLL   = 5'd7,
      OP_SRL   = 5'd8,
      OP_SRA   = 5'd9,
      OP_PACK  = 5'd10,
      OP_UNPLO = 5'd11,
      OP_UNPHI = 5'd12,
      OP_AND   = 5'd13,
      OP_ANDN  = 5'd14,
      OP_OR    = 5'd15,
      OP_XOR   = 5'd16
   } simd_op_e;

   // lane-size codes: width = 8 << code
   localparam int NUM_LSZ = 4;

endpackage

// File: rtl/simd_arith_slice.sv
`timescale 1ns/1ps
module simd_arith_slice #(
   parameter int DW = 64,
   parameter int LW = 8
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic          sub_i,
   input  logic          sat_i,
   input  logic          uns_i,
   output logic [DW-1:0] sum_o,
   output logic [DW-1:0] eq_o,
   output logic [DW-1:0] gt_o
);
   localparam int NL = DW / LW;

   for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [LW-1:0] x, y, yy, lane_r;
      logic [LW:0]   s;
      logic          sovf, uovf;

      assign x    = a_i[l*LW +: LW];
      assign y    = b_i[l*LW +: LW];
      assign yy   = sub_i ? ~y : y;
      assign s    = {1'b0, x} + {1'b0, yy} + {{LW{1'b0}}, sub_i};
      assign sovf = (x[LW-1] == yy[LW-1]) && (s[LW-1] != x[LW-1]);
      assign uovf = sub_i ? ~s[LW] : s[LW];

      always_comb begin
         lane_r = s[LW-1:0];
         if (sat_i) begin
            if (uns_i) begin
               if (uovf) lane_r = sub_i ? {LW{1'b0}} : {LW{1'b1}};
            end else if (sovf) begin
               lane_r = x[LW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
            end
         end
      end

      assign sum_o[l*LW +: LW] = lane_r;
      assign eq_o[l*LW +: LW]  = {LW{x == y}};
      assign gt_o[l*LW +: LW]  = {LW{$signed(x) > $signed(y)}};
   end

endmodule

// File: rtl/simd_shift_slice.sv
`timescale 1ns/1ps
module simd_shift_slice #(
   parameter int DW     = 64,
   parameter int LW     = 16,
   parameter bit SRA_EN = 1'b1
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic [DW-1:0] sll_o,
   output logic [DW-1:0] srl_o,
   output logic [DW-1:0] sra_o
);
   localparam int NL = DW / LW;
   localparam int CW = $clog2(LW);

   logic          big;
   logic [CW-1:0] amt, samt;

   assign big  = (b_i[63:CW] != '0);
   assign amt  = b_i[CW-1:0];
   assign samt = big ? CW'(LW - 1) : amt;

   for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [LW-1:0] x;
      assign x = a_i[l*LW +: LW];
      assign sll_o[l*LW +: LW] = big ? '0 : (x << amt);
      assign srl_o[l*LW +: LW] = big ? '0 : (x >> amt);
      if (SRA_EN) begin : g_sra
         assign sra_o[l*LW +: LW] = $signed(x) >>> samt;
      end else begin : g_nosra
         assign sra_o[l*LW +: LW] = '0;
      end
   end

endmodule

// File: rtl/simd_mul_unit.sv
`timescale 1ns/1ps
module simd_mul_unit #(
   parameter int DW = 64
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic [DW-1:0] lo_o,
   output logic [DW-1:0] hi_o,
   output logic [DW-1:0] madd_o
);
   localparam int NP = DW / 16;
   localparam int NS = DW / 32;

   logic [NP-1:0][31:0] prod;

   for (genvar l = 0; l < NP; l++) begin : g_prod
      assign prod[l] = 32'($signed(a_i[l*16 +: 16])) * 32'($signed(b_i[l*16 +: 16]));
      assign lo_o[l*16 +: 16] = prod[l][15:0];
      assign hi_o[l*16 +: 16] = prod[l][31:16];
   end

   for (genvar m = 0; m < NS; m++) begin : g_pair
      assign madd_o[m*32 +: 32] = prod[2*m] + prod[2*m+1];
   end

endmodule

// File: rtl/simd_perm_slice.sv
`timescale 1ns/1ps
module simd_perm_slice #(
   parameter int DW = 64,
   parameter int LW = 16
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic          uns_i,
   output logic [DW-1:0] pk_o,
   output logic [DW-1:0] ulo_o,
   output logic [DW-1:0] uhi_o
);
   localparam int NL = DW / LW;
   localparam int HL = NL / 2;
   localparam int HW = LW / 2;

   function automatic logic [HW-1:0] narrow(input logic [LW-1:0] v, input logic u);
      if (u) begin
         if (v[LW-1])            return '0;
         if (v[LW-1:HW] != '0)   return '1;
         return v[HW-1:0];
      end
      if (v[LW-1:HW-1] == '0 || v[LW-1:HW-1] == '1) return v[HW-1:0];
      return v[LW-1] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}};
   endfunction

   if (LW <= 32) begin : g_unpack
      for (genvar i = 0; i < HL; i++) begin : g_il
         assign ulo_o[(2*i)*LW   +: LW] = a_i[i*LW +: LW];
         assign ulo_o[(2*i+1)*LW +: LW] = b_i[i*LW +: LW];
         assign uhi_o[(2*i)*LW   +: LW] = a_i[(HL+i)*LW +: LW];
         assign uhi_o[(2*i+1)*LW +: LW] = b_i[(HL+i)*LW +: LW];
      end
   end else begin : g_nounpack
      assign ulo_o = '0;
      assign uhi_o = '0;
   end

   if (LW == 16 || LW == 32) begin : g_pack
      for (genvar i = 0; i < NL; i++) begin : g_nl
         assign pk_o[i*HW      +: HW] = narrow(a_i[i*LW +: LW], uns_i);
         assign pk_o[(NL+i)*HW +: HW] = narrow(b_i[i*LW +: LW], uns_i);
      end
   end else begin : g_nopack
      assign pk_o = '0;
   end

endmodule

// File: rtl/simd_alu.sv
`timescale 1ns/1ps
module simd_alu
   import simd_alu_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          valid_i,
   input  logic [4:0]    op_i,
   input  logic [1:0]    lsz_i,
   input  logic          sat_i,
   input  logic          uns_i,
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic          valid_o,
   output logic [DW-1:0] res_o
);
   if (DW < 64 || (DW % 64) != 0) begin : g_bad_dw
      $error("simd_alu: DW must be a positive multiple of 64");
   end

   logic [NUM_LSZ-1:0][DW-1:0] sum_w, eq_w, gt_w, sll_w, srl_w, sra_w, pk_w, ulo_w, uhi_w;
   logic [DW-1:0] mlo, mhi, madd, res_d;
   logic          is_sub;

   assign is_sub = (op_i == OP_SUB);

   for (genvar k = 0; k < NUM_LSZ; k++) begin : g_sz
      localparam int LW = 8 << k;
      if (k < 3) begin : g_ar
         simd_arith_slice #(.DW(DW), .LW(LW)) u_ar (
            .a_i(a_i), .b_i(b_i), .sub_i(is_sub), .sat_i(sat_i), .uns_i(uns_i),
            .sum_o(sum_w[k]), .eq_o(eq_w[k]), .gt_o(gt_w[k]));
      end else begin : g_noar
         assign sum_w[k] = '0;
         assign eq_w[k]  = '0;
         assign gt_w[k]  = '0;
      end
      if (k > 0) begin : g_sh
         simd_shift_slice #(.DW(DW), .LW(LW), .SRA_EN(k < 3)) u_sh (
            .a_i(a_i), .b_i(b_i),
            .sll_o(sll_w[k]), .srl_o(srl_w[k]), .sra_o(sra_w[k]));
      end else begin : g_nosh
         assign sll_w[k] = '0;
         assign srl_w[k] = '0;
         assign sra_w[k] = '0;
      end
      simd_perm_slice #(.DW(DW), .LW(LW)) u_pm (
         .a_i(a_i), .b_i(b_i), .uns_i(uns_i),
         .pk_o(pk_w[k]), .ulo_o(ulo_w[k]), .uhi_o(uhi_w[k]));
   end

   simd_mul_unit #(.DW(DW)) u_mul (
      .a_i(a_i), .b_i(b_i), .lo_o(mlo), .hi_o(mhi), .madd_o(madd));

   always_comb begin
      case (op_i)
         OP_ADD, OP_SUB: res_d = sum_w[lsz_i];
         OP_CMPEQ:       res_d = eq_w[lsz_i];
         OP_CMPGT:       res_d = gt_w[lsz_i];
         OP_MULLO:       res_d = mlo;
         OP_MULHI:       res_d = mhi;
         OP_MADD:        res_d = madd;
         OP_SLL:         res_d = sll_w[lsz_i];
         OP_SRL:         res_d = srl_w[lsz_i];
         OP_SRA:         res_d = sra_w[lsz_i];
         OP_PACK:        res_d = pk_w[lsz_i];
         OP_UNPLO:       res_d = ulo_w[lsz_i];
         OP_UNPHI:       res_d = uhi_w[lsz_i];
         OP_AND:         res_d = a_i & b_i;
         OP_ANDN:        res_d = a_i & ~b_i;
         OP_OR:          res_d = a_i | b_i;
         OP_XOR:         res_d = a_i ^ b_i;
         default:        res_d = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         res_o   <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) res_o <= res_d;
      end
   end

endmodule

// File: rtl/simd_alu_chk.sv
`timescale 1ns/1ps
module simd_alu_chk
   import simd_alu_pkg::*;
#(
   parameter int DW = 64
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          valid_i,
   input logic [4:0]    op_i,
   input logic [1:0]    lsz_i,
   input logic [DW-1:0] a_i,
   input logic [DW-1:0] b_i,
   input logic          valid_o,
   input logic [DW-1:0] res_o
);
   function automatic logic bytes_are_masks(input logic [DW-1:0] v);
      for (int i = 0; i < DW/8; i++)
         if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
      return 1'b1;
   endfunction

   AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);                                                  // R13
   AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);                                                // R13
   AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(res_o));                                          // R13
   AST_ANDNOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_ANDN) |=> res_o == ($past(a_i) & ~$past(b_i))); // R11
   AST_EQ_BYTE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_CMPEQ && lsz_i == 2'd0) |=> bytes_are_masks(res_o)); // R4
   AST_BAD_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i > OP_XOR) |=> res_o == '0);                           // R12
   AST_WIDE_ADD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && op_i == OP_ADD && lsz_i == 2'd3) |=> res_o == '0);          // R12

endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .lsz_i(lsz_i),
   .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o));

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        valid_i = 1'b0;
   logic [4:0]  op_i = '0;
   logic [1:0]  lsz_i = '0;
   logic        sat_i = 1'b0;
   logic        uns_i = 1'b0;
   logic [63:0] a_i = '0;
   logic [63:0] b_i = '0;
   logic        valid_o;
   logic [63:0] res_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   simd_alu #(.DW(64)) dut (
      .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .lsz_i(lsz_i),
      .sat_i(sat_i), .uns_i(uns_i), .a_i(a_i), .b_i(b_i),
      .valid_o(valid_o), .res_o(res_o));

   function automatic logic [63:0] lmask(int w);
      return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
   endfunction

   function automatic longint ux(logic [63:0] v, int i, int w);
      return longint'((v >> (i*w)) & lmask(w));
   endfunction

   function automatic longint sx(logic [63:0] v, int i, int w);
      longint t = ux(v, i, w);
      if (w < 64 && t[w-1]) t = t - (longint'(1) << w);
      return t;
   endfunction

   function automatic logic [63:0] put(logic [63:0] r, longint val, int i, int w);
      return r | ((64'(val) & lmask(w)) << (i*w));
   endfunction

   function automatic longint clamp(longint v, longint lo, longint hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   function automatic logic [63:0] model(int op, int lsz, bit sat, bit uns, logic [63:0] a, logic [63:0] b);
      logic [63:0] r = '0;
      int     w = 8 << lsz;
      int     n = 64 / w;
      longint v, p, q;
      case (op)
         0, 1: if (lsz < 3) for (int i = 0; i < n; i++) begin
            if (sat && !uns) v = (op == 0) ? sx(a,i,w) + sx(b,i,w) : sx(a,i,w) - sx(b,i,w);
            else             v = (op == 0) ? ux(a,i,w) + ux(b,i,w) : ux(a,i,w) - ux(b,i,w);
            if (sat && !uns) v = clamp(v, -(longint'(1) << (w-1)), (longint'(1) << (w-1)) - 1);
            if (sat && uns)  v = clamp(v, 0, (longint'(1) << w) - 1);
            r = put(r, v, i, w);
         end
         2, 3: if (lsz < 3) for (int i = 0; i < n; i++) begin
            if (op == 2) v = (ux(a,i,w) == ux(b,i,w)) ? -1 : 0;
            else         v = (sx(a,i,w) >  sx(b,i,w)) ? -1 : 0;
            r = put(r, v, i, w);
         end
         4, 5, 6: begin
            q = 0;
            for (int i = 0; i < 4; i++) begin
               p = sx(a,i,16) * sx(b,i,16);
               if (op == 4) r = put(r, p, i, 16);
               if (op == 5) r = put(r, p >>> 16, i, 16);
               if (op == 6 && i[0]) r = put(r, q + p, i/2, 32);
               q = p;
            end
         end
         7, 8: if (lsz >= 1) for (int i = 0; i < n; i++) begin
            logic [63:0] x;
            x = 64'(ux(a,i,w));
            if (b < 64'(w)) r = put(r, longint'((op == 7) ? (x << b) : (x >> b)), i, w);
         end
         9: if (lsz == 1 || lsz == 2) for (int i = 0; i < n; i++) begin
            v = sx(a,i,w) >>> ((b >= 64'(w)) ? (w-1) : int'(b));
            r = put(r, v, i, w);
         end
         10: if (lsz == 1 || lsz == 2) for (int i = 0; i < n; i++) begin
            longint lo = uns ? 0 : -(longint'(1) << (w/2-1));
            longint hi = uns ? ((longint'(1) << (w/2)) - 1) : ((longint'(1) << (w/2-1)) - 1);
            r = put(r, clamp(sx(a,i,w), lo, hi), i, w/2);
            r = put(r, clamp(sx(b,i,w), lo, hi), n+i, w/2);
         end
         11, 12: if (lsz < 3) for (int i = 0; i < n/2; i++) begin
            int base = (op == 11) ? 0 : n/2;
            r = put(r, ux(a,base+i,w), 2*i, w);
            r = put(r, ux(b,base+i,w), 2*i+1, w);
         end
         13: r = a & b;
         14: r = a & ~b;
         15: r = a | b;
         16: r = a ^ b;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic bit unsupported(int op, int lsz);
      if (op > 16) return 1'b1;
      if (op <= 3 || op == 11 || op == 12) return lsz == 3;
      if (op == 7 || op == 8) return lsz == 0;
      if (op == 9 || op == 10) return (lsz == 0 || lsz == 3);
      return 1'b0;
   endfunction

   function automatic string tag(int op, int lsz, bit sat, bit uns);
      if (unsupported(op, lsz)) return "R12";
      case (op)
         0, 1:    return sat ? (uns ? "R3" : "R2") : "R1";
         2, 3:    return "R4";
         4, 5:    return "R5";
         6:       return "R6";
         7, 8:    return "R7";
         9:       return "R8";
         10:      return "R9";
         11, 12:  return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(int op, int lsz, bit sat, bit uns, logic [63:0] a, logic [63:0] b);
      logic [63:0] exp;
      exp = model(op, lsz, sat, uns, a, b);
      @(negedge clk);
      op_i = 5'(op); lsz_i = 2'(lsz); sat_i = sat; uns_i = uns;
      a_i = a; b_i = b; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      check(res_o === exp && valid_o === 1'b1, tag(op, lsz, sat, uns), res_o, exp);
   endtask

   function automatic logic [63:0] flavour(logic [63:0] v, int sel);
      case (sel)
         0: return v | 64'h8080_8080_8080_8080;
         1: return v & 64'h7F7F_7F7F_7F7F_7F7F;
         2: return v | 64'hFFFF_0000_FFFF_0000;
         default: return v;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      void'($urandom(32'd7319));
      repeat (3) @(negedge clk);
      check(res_o === '0 && valid_o === 1'b0, "R13", res_o, '0);
      rst_ni = 1'b1;

      issue(0, 0, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);        // R1 no cross-lane carry
      issue(0, 1, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);        // R1 16-bit lanes
      issue(1, 2, 0, 0, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006);        // R1 borrow stays in lane
      issue(0, 0, 1, 0, 64'h7F7F_7F7F_0101_8080, 64'h0101_0101_0101_FFFF);        // R2 clamp max/min
      issue(1, 0, 1, 0, 64'h8080_0000_0000_0000, 64'h0101_0000_0000_0000);        // R2 clamp min
      issue(0, 1, 1, 1, 64'hFFFF_0001_0000_8000, 64'h0001_0001_0000_8000);        // R3 clamp all ones
      issue(1, 1, 1, 1, 64'h0000_0005_0003_0000, 64'h0001_0003_0005_0000);        // R3 clamp zero
      issue(3, 2, 0, 0, 64'hFFFF_FFFF_0000_0002, 64'h0000_0001_0000_0001);        // R4 signed greater
      issue(2, 0, 0, 0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700);        // R4 equal bytes
      issue(5, 0, 0, 0, 64'h8000_7FFF_FFFF_0002, 64'h8000_7FFF_0002_0003);        // R5 high half
      issue(4, 3, 0, 0, 64'h8000_7FFF_FFFF_0002, 64'h8000_7FFF_0002_0003);        // R5 low half
      issue(6, 0, 0, 0, 64'h8000_8000_0003_0002, 64'h8000_8000_0005_FFFF);        // R6 wraps at 2^31
      issue(8, 1, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'd16);                         // R7 count == width
      issue(7, 3, 0, 0, 64'h0000_0000_0000_0001, 64'd63);                         // R7 64-bit lane
      issue(9, 2, 0, 0, 64'h8000_0000_7FFF_FFFF, 64'd100);                        // R8 sign fill
      issue(9, 1, 0, 0, 64'h8000_4000_F00F_0FF0, 64'd3);                          // R8 in range
      issue(10, 1, 0, 0, 64'h0080_FF7F_007F_FF80, 64'h8000_7FFF_0001_FFFF);       // R9 signed narrow
      issue(10, 1, 0, 1, 64'h0080_FF7F_0100_00FF, 64'h8000_7FFF_0001_FFFF);       // R9 unsigned narrow
      issue(10, 2, 0, 0, 64'h0001_0000_FFFF_0000, 64'h0000_7FFF_8000_0000);       // R9 32-bit source
      issue(12, 0, 0, 0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988);       // R10 high bytes
      issue(11, 2, 0, 0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988);       // R10 low words
      issue(14, 0, 0, 0, 64'hF0F0_F0F0_FFFF_0000, 64'hFF00_FF00_0F0F_FFFF);       // R11
      issue(0, 3, 0, 0, 64'h1, 64'h1);                                            // R12
      issue(7, 0, 0, 0, 64'h1, 64'h1);                                            // R12
      issue(20, 1, 0, 0, 64'hFFFF, 64'hFFFF);                                     // R12

      // R13: result held while valid_i stays low
      held = res_o;
      a_i = ~a_i; op_i = 5'd13;
      @(negedge clk);
      check(res_o === held && valid_o === 1'b0, "R13", res_o, held);

      for (int t = 0; t < 600; t++) begin
         int          op  = $urandom_range(0, 18);
         int          lsz = $urandom_range(0, 3);
         logic [63:0] a   = flavour({$urandom, $urandom}, $urandom_range(0, 4));
         logic [63:0] b   = flavour({$urandom, $urandom}, $urandom_range(0, 4));
         if (op >= 7 && op <= 9) b = 64'($urandom_range(0, 79));
         issue(op, lsz, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, b);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule